// File: doc/BRIEF.md
# Frequency-Select Strap Capture

This block takes a three-bit frequency-select strap and locks it in once, when the active-low power-good input is first seen asserted after reset. The strap pins are only valid once the processor supply has settled. Power-good falling marks that point, so the block ignores strap values seen before it. After the capture, the frozen code drives the frequency-selection logic downstream, and later activity on the pins or on power-good has no effect. A test-mode input lifts the lock: while it is high, the code follows the pins for as long as power-good is asserted.

The strap pins and power-good are asynchronous to the block clock, so each one passes through a multi-stage synchronizer before use. The test-mode input is a static strap and is used directly. The block also flags the single reserved encoding. Of the eight codes, seven select host frequencies between 100 and 400 MHz and one is reserved.

Top module: `fsel_strap_latch`

## Requirements
- R1: While reset is asserted and after its release, `sel_code` equals the default code 3'b001, `sel_valid` is 0 and `sel_rsvd` is 0, until the first capture.
- R2: When `pg_n` is held low, the block captures `fs_pins` as they stood in the same clock as `pg_n`. The value appears on `sel_code` together with `sel_valid`=1 no later than the third rising clock edge after the change. Bit 2 is the C strap, bit 1 the B strap and bit 0 the A strap, and the bits are copied unmodified.
- R3: While `pg_n` stays high, changes on `fs_pins` do not alter `sel_code` and do not set `sel_valid`.
- R4: With `test_en` low, once `sel_valid` is 1, any later change on `fs_pins` or `pg_n` leaves `sel_code` unchanged.
- R5: With `test_en` high, `sel_code` reloads from the synchronized pins on every clock in which the synchronized `pg_n` is low, and holds while it is high.
- R6: `sel_rsvd` is 1 exactly when `sel_code` equals the reserved encoding 3'b101.
- R7: `sel_valid` returns to 0 only through reset. When `test_en` falls, the last code taken in test mode stays locked.
- R8: A low pulse on `pg_n` that lasts a single clock period, driven between edges, is enough to trigger the capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fs_pins | input | 3 | Frequency-select strap pins, asynchronous: {C, B, A} |
| pg_n | input | 1 | Active-low power-good, asynchronous |
| test_en | input | 1 | Static test-mode strap; high removes the one-shot lock |
| sel_code | output | 3 | Captured frequency-select code |
| sel_valid | output | 1 | High once a capture has taken place |
| sel_rsvd | output | 1 | High while sel_code holds the reserved encoding |

## Verification
The hardest case to reach is proving that the lock holds against activity arriving after the capture, because the block gives no sign when it ignores an input. The bench first makes a capture with a random code. It then drives many cycles of random toggling on both the strap pins and power-good, including power-good going high and low again, and checks the code on every cycle. Directed cases cover pin changes before power-good, a one-cycle power-good pulse, and leaving test mode while the code was tracking the pins.

// File: rtl/fsel_pkg.sv
package fsel_pkg;

   localparam int unsigned FSEL_W = 3;

   typedef logic [FSEL_W-1:0] fsel_code_t;

   localparam fsel_code_t FSEL_DEFAULT  = 3'b001;
   localparam fsel_code_t FSEL_RESERVED = 3'b101;

   typedef enum logic [1:0] {
      CAP_WAIT   = 2'd0,
      CAP_LOCKED = 2'd1,
      CAP_TRACK  = 2'd2
   } cap_state_t;

endpackage

// File: rtl/fsel_sync.sv
module fsel_sync #(
   parameter int unsigned WIDTH     = 1,
   parameter int unsigned STAGES    = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_async,
   output logic [WIDTH-1:0] q_sync
);

   localparam int unsigned LAST = STAGES - 1;

   if (STAGES < 2) begin : g_bad_stages
      $error("fsel_sync: STAGES must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("fsel_sync: WIDTH must be at least 1");
   end

   logic [WIDTH-1:0] chain [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[s] <= RST_VAL;
            else        chain[s] <= d_async;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[s] <= RST_VAL;
            else        chain[s] <= chain[s-1];
         end
      end
   end

   assign q_sync = chain[LAST];

endmodule

// File: rtl/fsel_capture.sv
module fsel_capture
   import fsel_pkg::*;
#(
   parameter int unsigned CODE_W   = FSEL_W,
   parameter logic [CODE_W-1:0] DEF_CODE = FSEL_DEFAULT
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CODE_W-1:0] pins_s,
   input  logic              pg_act_s,
   input  logic              test_en,
   output logic [CODE_W-1:0] code_q,
   output logic              valid_q
);

   cap_state_t state_q, state_d;
   logic [CODE_W-1:0] code_d;

   always_comb begin
      state_d = state_q;
      code_d  = code_q;
      unique case (state_q)
         CAP_WAIT: begin
            if (pg_act_s) begin
               code_d  = pins_s;
               state_d = test_en ? CAP_TRACK : CAP_LOCKED;
            end else if (test_en) begin
               state_d = CAP_WAIT;
            end
         end
         CAP_LOCKED: begin
            if (test_en) begin
               state_d = CAP_TRACK;
               if (pg_act_s) code_d = pins_s;
            end
         end
         CAP_TRACK: begin
            if (pg_act_s) code_d = pins_s;
            if (!test_en) state_d = CAP_LOCKED;
         end
         default: state_d = CAP_WAIT;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= CAP_WAIT;
         code_q  <= DEF_CODE;
      end else begin
         state_q <= state_d;
         code_q  <= code_d;
      end
   end

   assign valid_q = (state_q != CAP_WAIT);

endmodule

// File: rtl/fsel_decode.sv
module fsel_decode
   import fsel_pkg::*;
#(
   parameter int unsigned CODE_W = FSEL_W,
   parameter logic [CODE_W-1:0] RSVD_CODE = FSEL_RESERVED
) (
   input  logic [CODE_W-1:0] code,
   output logic              rsvd
);

   assign rsvd = (code == RSVD_CODE);

endmodule

// File: rtl/fsel_strap_latch.sv
module fsel_strap_latch
   import fsel_pkg::*;
#(
   parameter int unsigned CODE_W      = FSEL_W,
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          PG_ACT_LOW  = 1'b1,
   parameter logic [CODE_W-1:0] DEF_CODE  = FSEL_DEFAULT,
   parameter logic [CODE_W-1:0] RSVD_CODE = FSEL_RESERVED
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CODE_W-1:0] fs_pins,
   input  logic              pg_n,
   input  logic              test_en,
   output logic [CODE_W-1:0] sel_code,
   output logic              sel_valid,
   output logic              sel_rsvd
);

   localparam logic PG_IDLE = PG_ACT_LOW ? 1'b1 : 1'b0;

   if (CODE_W != FSEL_W) begin : g_bad_w
      $error("fsel_strap_latch: CODE_W must match the package code width");
   end
   if (DEF_CODE == RSVD_CODE) begin : g_bad_def
      $error("fsel_strap_latch: default code must not be the reserved code");
   end

   logic [CODE_W-1:0] pins_s;
   logic              pg_raw_s;
   logic              pg_act_s;

   fsel_sync #(.WIDTH(CODE_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_pin_sync (
      .clk(clk), .rst_n(rst_n), .d_async(fs_pins), .q_sync(pins_s)
   );

   fsel_sync #(.WIDTH(1), .STAGES(SYNC_STAGES), .RST_VAL(PG_IDLE)) u_pg_sync (
      .clk(clk), .rst_n(rst_n), .d_async(pg_n), .q_sync(pg_raw_s)
   );

   if (PG_ACT_LOW) begin : g_pg_low
      assign pg_act_s = ~pg_raw_s;
   end else begin : g_pg_high
      assign pg_act_s = pg_raw_s;
   end

   fsel_capture #(.CODE_W(CODE_W), .DEF_CODE(DEF_CODE)) u_cap (
      .clk(clk), .rst_n(rst_n), .pins_s(pins_s), .pg_act_s(pg_act_s),
      .test_en(test_en), .code_q(sel_code), .valid_q(sel_valid)
   );

   fsel_decode #(.CODE_W(CODE_W), .RSVD_CODE(RSVD_CODE)) u_dec (
      .code(sel_code), .rsvd(sel_rsvd)
   );

endmodule

// File: rtl/fsel_strap_latch_chk.sv
module fsel_strap_latch_chk #(
   parameter int unsigned CODE_W = 3,
   parameter logic [CODE_W-1:0] DEF_CODE  = 3'b001,
   parameter logic [CODE_W-1:0] RSVD_CODE = 3'b101
) (
   input logic              clk,
   input logic              rst_n,
   input logic              test_en,
   input logic [CODE_W-1:0] sel_code,
   input logic              sel_valid,
   input logic              sel_rsvd
);

   AST_DEFAULT_BEFORE_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
      !sel_valid |-> sel_code == DEF_CODE); // R1

   AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_valid && !test_en) |=> (sel_valid && $stable(sel_code))); // R4

   AST_RSVD_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      sel_rsvd == (sel_code == RSVD_CODE)); // R6

   AST_VALID_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      sel_valid |=> sel_valid); // R7

endmodule

bind fsel_strap_latch fsel_strap_latch_chk #(
   .CODE_W(CODE_W), .DEF_CODE(DEF_CODE), .RSVD_CODE(RSVD_CODE)
) u_chk (
   .clk(clk), .rst_n(rst_n), .test_en(test_en),
   .sel_code(sel_code), .sel_valid(sel_valid), .sel_rsvd(sel_rsvd)
);

// File: tb/fsel_strap_latch_test.sv
`timescale 1ns/1ps
module fsel_strap_latch_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] fs_pins = 3'b000;
   logic       pg_n = 1'b1;
   logic       test_en = 1'b0;
   logic [2:0] sel_code;
   logic       sel_valid;
   logic       sel_rsvd;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   fsel_strap_latch uut (
      .clk(clk), .rst_n(rst_n), .fs_pins(fs_pins), .pg_n(pg_n),
      .test_en(test_en), .sel_code(sel_code), .sel_valid(sel_valid),
      .sel_rsvd(sel_rsvd)
   );

   function automatic logic exp_rsvd(input logic [2:0] c);
      return c == 3'b101;
   endfunction

   task automatic check(input string req, input logic [2:0] exp_c, input logic exp_v);
      checks++;
      if (sel_code !== exp_c || sel_valid !== exp_v || sel_rsvd !== exp_rsvd(exp_c)) begin
         errors++;
         $display("FAIL %s: code=%b valid=%b rsvd=%b expected code=%b valid=%b rsvd=%b",
                   req, sel_code, sel_valid, sel_rsvd, exp_c, exp_v, exp_rsvd(exp_c));
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; pg_n = 1'b1; test_en = 1'b0;
      cyc(2);
      rst_n = 1'b1;
      cyc(1);
   endtask

   initial begin
      logic [2:0] c;
      logic [2:0] lat;
      void'($urandom(32'h5EED_0C1A));
      cyc(2);
      check("R1 in reset", 3'b001, 1'b0);
      rst_n = 1'b1;
      cyc(3);
      check("R1 after reset", 3'b001, 1'b0);

      // R3: pin activity before power-good
      for (int i = 0; i < 20; i++) begin
         fs_pins = 3'($urandom);
         cyc(1);
         check("R3 pins before pg", 3'b001, 1'b0);
      end

      // R2 latency: code valid at third edge
      fs_pins = 3'b110; pg_n = 1'b0;
      cyc(2);
      check("R2 not yet", 3'b001, 1'b0);
      cyc(1);
      check("R2 capture latency", 3'b110, 1'b1);

      // R2/R4/R6 random trials with every code
      for (int t = 0; t < 24; t++) begin
         do_reset();
         c = (t < 8) ? 3'(t) : 3'($urandom);
         fs_pins = c;
         cyc(2);
         pg_n = 1'b0;
         cyc(4);
         check("R2 capture", c, 1'b1);
         check("R6 reserved flag", c, 1'b1);
         for (int k = 0; k < 40; k++) begin
            fs_pins = 3'($urandom);
            pg_n = 1'($urandom);
            cyc(1);
            check("R4 lock holds", c, 1'b1);
         end
      end

      // R8: single-cycle power-good pulse
      do_reset();
      fs_pins = 3'b011;
      cyc(1);
      pg_n = 1'b0;
      cyc(1);
      pg_n = 1'b1;
      fs_pins = 3'b100;
      cyc(4);
      check("R8 one-cycle pulse", 3'b011, 1'b1);

      // R5: test mode tracking
      do_reset();
      test_en = 1'b1;
      fs_pins = 3'b010;
      cyc(3);
      check("R5 test no pg", 3'b001, 1'b0);
      pg_n = 1'b0;
      cyc(4);
      check("R5 test capture", 3'b010, 1'b1);
      lat = 3'b010;
      for (int k = 0; k < 30; k++) begin
         fs_pins = 3'($urandom);
         cyc(4);
         lat = fs_pins;
         check("R5 test follows pins", lat, 1'b1);
      end
      pg_n = 1'b1;
      cyc(3);
      fs_pins = ~lat;
      cyc(4);
      check("R5 test holds with pg high", lat, 1'b1);
      pg_n = 1'b0;
      cyc(4);
      lat = ~lat;
      check("R5 test reload on pg low", lat, 1'b1);

      // R7: leaving test mode locks the last code
      test_en = 1'b0;
      cyc(1);
      for (int k = 0; k < 20; k++) begin
         fs_pins = 3'($urandom);
         pg_n = 1'($urandom);
         cyc(1);
         check("R7 locked after test exit", lat, 1'b1);
      end
      rst_n = 1'b0;
      cyc(1);
      check("R7 cleared by reset", 3'b001, 1'b0);
      rst_n = 1'b1;
      cyc(2);

      done = 1'b1;
   end

   initial begin
      fork
         begin
            wait (done);
         end
         begin
            repeat (150000) @(posedge clk);
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
         end
      join_any
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule